// File: doc/BRIEF.md
# Host Address Range Decoder

This block examines every memory or I/O request issued by the host processor and chooses where it goes: system SDRAM, the downstream hub port (the PCI-style path), the graphics port, the internal graphics device, or a local sink that ends the cycle itself. The choice depends on the request address, the read/write direction, the memory/I/O flag and a few configuration inputs. These inputs are a top-of-memory value, a steering select for the legacy video window, and a two-bit access attribute for each slice of the upper legacy area below 1 MB.

The decision is registered. One clock after a request strobe the block presents a one-hot target select. A read that the sink terminates completes in that same cycle with all-zero data. Memory addresses at or above 4 GB are never forwarded downstream. Writes to them are discarded and reads to them return zeros.

Top module: `host_range_decoder`

## Requirements
- R1: `tgt_valid` is high exactly in the cycle after a cycle with `req_valid` high. In that cycle `tgt_sel` has exactly one bit set. When `tgt_valid` is low, `tgt_sel` is zero. Bit encoding of `tgt_sel`: bit0 SDRAM, bit1 hub port, bit2 graphics port, bit3 internal graphics, bit4 sink.
- R2: A memory request with any address bit at position 32 or above set selects the sink. It never selects the hub port or the graphics port, whatever the configuration.
- R3: A write that the sink terminates produces no completion: `cpl_valid` stays low.
- R4: A read that the sink terminates raises `cpl_valid` in the same cycle as `tgt_valid`, and `cpl_data` is zero.
- R5: A memory request in 0xA0000–0xBFFFF is steered by `cfg_vga_route`: 01 selects the graphics port, 10 selects internal graphics, and 00 or 11 selects the hub port. This takes precedence over the attribute regions and SDRAM.
- R6: The window 0xC0000–0xFFFFF is cut into `LOW_REGIONS` equal slices; with defaults, slice i starts at 0xC0000 + i·0x8000. Slice i uses `cfg_low_attr[2i+1:2i]`: 00 disabled, 01 read-only, 10 write-only, 11 read/write. A permitted access selects SDRAM. A refused access selects the hub port.
- R7: Any other memory request below 4 GB selects SDRAM when address bits [31:20] (the megabyte number) are below the effective top of memory. Otherwise it selects the hub port.
- R8: The effective top of memory is `cfg_tom_mb` (in MB) limited to 2048. A larger programmed value decodes as 2 GB.
- R9: An I/O request with address up to and including 0x10002 selects the hub port. A larger I/O address selects the sink and is terminated as in R3/R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, one cycle per request |
| req_addr | input | ADDR_W | Request byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = I/O space, 0 = memory space |
| cfg_tom_mb | input | 12 | Top of SDRAM in MB |
| cfg_vga_route | input | 2 | Legacy video window steering |
| cfg_low_attr | input | 2*LOW_REGIONS | Per-slice access attributes |
| tgt_valid | output | 1 | Decision valid |
| tgt_sel | output | 5 | One-hot destination |
| cpl_valid | output | 1 | Local completion of a terminated read |
| cpl_data | output | DATA_W | Completion data, always zero |

## Verification
The assertions assume the configuration inputs do not change during the cycle a request is sampled. They also assume at most one request per clock, with no overlap among the video window, the attribute window and the top-of-memory range. The stimulus changes configuration only between requests, on the falling edge. Its addresses come from one of several classes: legacy video, the attribute slices, the SDRAM and hub ranges, the space above 4 GB, and the I/O boundary. Because the fixed windows are disjoint by construction, overlap never occurs.

// File: rtl/hrd_pkg.sv
package hrd_pkg;
  localparam int TGT_W = 5;
  typedef logic [TGT_W-1:0] tgt_t;
  localparam tgt_t TGT_SDRAM = 5'b00001;
  localparam tgt_t TGT_HUB   = 5'b00010;
  localparam tgt_t TGT_GFX   = 5'b00100;
  localparam tgt_t TGT_IGD   = 5'b01000;
  localparam tgt_t TGT_SINK  = 5'b10000;
  localparam logic [31:0] VGA_LO   = 32'h000A_0000;
  localparam logic [31:0] VGA_HI   = 32'h000B_FFFF;
  localparam logic [31:0] LOW_BASE = 32'h000C_0000;
  localparam logic [31:0] LOW_SPAN = 32'h0004_0000;
  localparam logic [11:0] TOM_CAP_MB = 12'd2048;
  localparam logic [31:0] IO_LAST  = 32'h0001_0002;
endpackage

// File: rtl/hrd_window_cmp.sv
module hrd_window_cmp #(
  parameter int ADDR_W = 36
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [11:0]       tom_mb,
  output logic              above_4g,
  output logic              in_vga,
  output logic              below_tom
);
  import hrd_pkg::*;
  localparam int HI_W = ADDR_W - 32;

  logic [11:0] tom_eff;

  always_comb begin
    above_4g  = (addr[ADDR_W-1:32] != {HI_W{1'b0}});
    in_vga    = (addr[31:0] >= VGA_LO) && (addr[31:0] <= VGA_HI);
    tom_eff   = (tom_mb > TOM_CAP_MB) ? TOM_CAP_MB : tom_mb;
    below_tom = (addr[31:20] < tom_eff);
  end
endmodule

// File: rtl/hrd_low_attr.sv
module hrd_low_attr #(
  parameter int REGIONS = 8
) (
  input  logic [31:0]          addr,
  input  logic                 is_write,
  input  logic [2*REGIONS-1:0] attr,
  output logic                 in_window,
  output logic                 permit
);
  import hrd_pkg::*;
  localparam int SLICE  = LOW_SPAN / REGIONS;
  localparam int SH     = $clog2(SLICE);
  localparam int IDX_W  = (REGIONS > 1) ? $clog2(REGIONS) : 1;

  logic [REGIONS-1:0] allow;
  logic [31:0]        rel;
  logic [IDX_W-1:0]   idx;

  for (genvar i = 0; i < REGIONS; i++) begin : g_slice
    assign allow[i] = is_write ? attr[2*i+1] : attr[2*i];
  end

  always_comb begin
    in_window = (addr >= LOW_BASE) && (addr < LOW_BASE + LOW_SPAN);
    rel       = (addr - LOW_BASE) >> SH;
    idx       = rel[IDX_W-1:0];
    permit    = allow[idx];
  end
endmodule

// File: rtl/hrd_io_check.sv
module hrd_io_check #(
  parameter int ADDR_W = 36
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              io_ok
);
  import hrd_pkg::*;
  always_comb io_ok = (addr <= ADDR_W'(IO_LAST));
endmodule

// File: rtl/host_range_decoder.sv
module host_range_decoder #(
  parameter int ADDR_W      = 36,
  parameter int DATA_W      = 64,
  parameter int LOW_REGIONS = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic                     req_write,
  input  logic                     req_io,
  input  logic [11:0]              cfg_tom_mb,
  input  logic [1:0]               cfg_vga_route,
  input  logic [2*LOW_REGIONS-1:0] cfg_low_attr,
  output logic                     tgt_valid,
  output logic [4:0]               tgt_sel,
  output logic                     cpl_valid,
  output logic [DATA_W-1:0]        cpl_data
);
  import hrd_pkg::*;

  logic above_4g, in_vga, below_tom, in_low, low_ok, io_ok;
  tgt_t sel_d, sel_q;
  logic vld_d, vld_q, cpl_d, cpl_q;

  hrd_window_cmp #(.ADDR_W(ADDR_W)) u_win (
    .addr(req_addr), .tom_mb(cfg_tom_mb),
    .above_4g(above_4g), .in_vga(in_vga), .below_tom(below_tom)
  );

  hrd_low_attr #(.REGIONS(LOW_REGIONS)) u_low (
    .addr(req_addr[31:0]), .is_write(req_write), .attr(cfg_low_attr),
    .in_window(in_low), .permit(low_ok)
  );

  hrd_io_check #(.ADDR_W(ADDR_W)) u_io (
    .addr(req_addr), .io_ok(io_ok)
  );

  // next-state: fixed priority decode
  always_comb begin
    sel_d = '0;
    if (req_valid) begin
      if (req_io)          sel_d = io_ok ? TGT_HUB : TGT_SINK;
      else if (above_4g)   sel_d = TGT_SINK;
      else if (in_vga) begin
        unique case (cfg_vga_route)
          2'b01:   sel_d = TGT_GFX;
          2'b10:   sel_d = TGT_IGD;
          default: sel_d = TGT_HUB;
        endcase
      end
      else if (in_low)     sel_d = low_ok ? TGT_SDRAM : TGT_HUB;
      else if (below_tom)  sel_d = TGT_SDRAM;
      else                 sel_d = TGT_HUB;
    end
    vld_d = req_valid;
    cpl_d = req_valid && !req_write && (sel_d == TGT_SINK);
  end

  // register stage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      vld_q <= 1'b0;
      cpl_q <= 1'b0;
    end else begin
      sel_q <= sel_d;
      vld_q <= vld_d;
      cpl_q <= cpl_d;
    end
  end

  assign tgt_valid = vld_q;
  assign tgt_sel   = sel_q;
  assign cpl_valid = cpl_q;
  assign cpl_data  = '0;
endmodule

// File: rtl/hrd_checker.sv
module hrd_checker #(
  parameter int ADDR_W = 36,
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [ADDR_W-1:0] req_addr,
  input logic              req_write,
  input logic              req_io,
  input logic              tgt_valid,
  input logic [4:0]        tgt_sel,
  input logic              cpl_valid,
  input logic [DATA_W-1:0] cpl_data
);
  logic armed;
  logic hi_mem;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end
  assign hi_mem = req_valid && !req_io && (req_addr[ADDR_W-1:32] != '0);

  // R1
  valid_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (tgt_valid == $past(req_valid)));
  // R1
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_valid |-> $countones(tgt_sel) == 1);
  // R1
  sel_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tgt_valid |-> tgt_sel == 5'b0);
  // R2
  high_addr_sink_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hi_mem |=> tgt_sel == 5'b10000);
  // R3
  write_no_cpl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write) |=> !cpl_valid);
  // R4
  read_cpl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_valid && tgt_sel[4] && armed && !$past(req_write)) |-> (cpl_valid && cpl_data == '0));
  // R4
  cpl_only_sink_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_valid |-> (tgt_valid && tgt_sel[4]));
endmodule

bind host_range_decoder hrd_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_hrd_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
  .req_write(req_write), .req_io(req_io), .tgt_valid(tgt_valid),
  .tgt_sel(tgt_sel), .cpl_valid(cpl_valid), .cpl_data(cpl_data)
);

// File: tb/host_range_decoder_test.sv
module host_range_decoder_test;
  localparam int ADDR_W = 36;
  localparam int DATA_W = 64;
  localparam int NREG   = 8;

  logic clk, rst_n;
  logic req_valid, req_write, req_io;
  logic [ADDR_W-1:0] req_addr;
  logic [11:0] cfg_tom_mb;
  logic [1:0]  cfg_vga_route;
  logic [2*NREG-1:0] cfg_low_attr;
  logic tgt_valid, cpl_valid;
  logic [4:0] tgt_sel;
  logic [DATA_W-1:0] cpl_data;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  host_range_decoder #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LOW_REGIONS(NREG)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_write(req_write), .req_io(req_io), .cfg_tom_mb(cfg_tom_mb),
    .cfg_vga_route(cfg_vga_route), .cfg_low_attr(cfg_low_attr),
    .tgt_valid(tgt_valid), .tgt_sel(tgt_sel), .cpl_valid(cpl_valid), .cpl_data(cpl_data)
  );

  initial clk = 0;
  always #2 clk = ~clk;

  task automatic check(string rq, logic [63:0] got, logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", rq, got, exp);
    end
  endtask

  function automatic logic [4:0] exp_sel(logic [ADDR_W-1:0] a, bit wr, bit io);
    logic [31:0] lo;
    logic [11:0] tom;
    int r;
    logic [1:0] at;
    lo = a[31:0];
    if (io) return (a <= 36'h10002) ? 5'b00010 : 5'b10000;
    if (a[ADDR_W-1:32] != 0) return 5'b10000;
    if (lo >= 32'hA0000 && lo < 32'hC0000)
      return (cfg_vga_route == 2'b01) ? 5'b00100 : (cfg_vga_route == 2'b10) ? 5'b01000 : 5'b00010;
    if (lo >= 32'hC0000 && lo < 32'h100000) begin
      r  = int'((lo - 32'hC0000) >> 15);
      at = cfg_low_attr[2*r +: 2];
      return (wr ? at[1] : at[0]) ? 5'b00001 : 5'b00010;
    end
    tom = (cfg_tom_mb > 12'd2048) ? 12'd2048 : cfg_tom_mb;
    return (lo[31:20] < tom) ? 5'b00001 : 5'b00010;
  endfunction

  function automatic string req_of(logic [ADDR_W-1:0] a, bit io);
    if (io) return "R9";
    if (a[ADDR_W-1:32] != 0) return "R2";
    if (a[31:0] >= 32'hA0000 && a[31:0] < 32'hC0000) return "R5";
    if (a[31:0] >= 32'hC0000 && a[31:0] < 32'h100000) return "R6";
    if (cfg_tom_mb > 12'd2048) return "R8";
    return "R7";
  endfunction

  // drive at negedge, sample at the following negedge (one register stage)
  task automatic do_req(logic [ADDR_W-1:0] a, bit wr, bit io);
    logic [4:0] e;
    string rq;
    req_valid = 1; req_addr = a; req_write = wr; req_io = io;
    e  = exp_sel(a, wr, io);
    rq = req_of(a, io);
    @(negedge clk);
    req_valid = 0;
    check("R1 valid", 64'(tgt_valid), 64'd1);
    check(rq, 64'(tgt_sel), 64'(e));
    if (e == 5'b10000 && !wr) begin
      check("R4 cpl", 64'(cpl_valid), 64'd1);
      check("R4 data", cpl_data, 64'd0);
    end else begin
      check(wr ? "R3 no cpl" : "R1 no cpl", 64'(cpl_valid), 64'd0);
    end
  endtask

  function automatic logic [ADDR_W-1:0] rnd_addr(output bit io);
    int k;
    k  = int'($urandom % 7);
    io = 0;
    case (k)
      0: return ADDR_W'($urandom % 32'hA0000);
      1: return ADDR_W'(32'hA0000 + $urandom % 32'h20000);
      2: return ADDR_W'(32'hC0000 + $urandom % 32'h40000);
      3: return ADDR_W'(32'h100000 + $urandom % 32'h7FF00000);
      4: return ADDR_W'($urandom);
      5: return {4'(1 + $urandom % 15), 32'($urandom)};
      default: begin
        io = 1;
        return ($urandom % 2) ? ADDR_W'(32'hFFF8 + $urandom % 16) : ADDR_W'($urandom % 32'h20000);
      end
    endcase
  endfunction

  initial begin
    #150000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED1));
    rst_n = 0; req_valid = 0; req_addr = '0; req_write = 0; req_io = 0;
    cfg_tom_mb = 12'd512; cfg_vga_route = 2'b00; cfg_low_attr = 16'h1B1B;
    repeat (3) @(negedge clk);
    check("R1 reset valid", 64'(tgt_valid), 0);
    check("R1 reset sel", 64'(tgt_sel), 0);
    check("R1 reset cpl", 64'(cpl_valid), 0);
    rst_n = 1;
    @(negedge clk);
    check("R1 idle sel", 64'(tgt_sel), 0);

    // directed corners
    do_req(36'h1_0000_0000, 0, 0);   // R2 read at exactly 4 GB
    do_req(36'h1_0000_0000, 1, 0);   // R3 dropped write
    do_req(36'hF_FFFF_FFFF, 0, 0);   // R4
    do_req(36'h10002, 0, 1);         // R9 last accepted I/O
    do_req(36'h10003, 0, 1);         // R9 terminated I/O read
    do_req(36'h10003, 1, 1);         // R9 terminated I/O write
    cfg_vga_route = 2'b01; do_req(36'hA0000, 0, 0);   // R5
    cfg_vga_route = 2'b10; do_req(36'hBFFFF, 1, 0);   // R5
    cfg_vga_route = 2'b11; do_req(36'hB0000, 0, 0);   // R5
    cfg_low_attr = 16'b11_10_01_00_11_10_01_00;
    for (int i = 0; i < NREG; i++) begin              // R6 every slice both ways
      do_req(ADDR_W'(32'hC0000 + i * 32'h8000 + 32'h7FFF), 0, 0);
      do_req(ADDR_W'(32'hC0000 + i * 32'h8000), 1, 0);
    end
    cfg_tom_mb = 12'd512;
    do_req(36'h1FFF_FFFF, 0, 0);     // R7 last MB below top
    do_req(36'h2000_0000, 0, 0);     // R7 at top -> hub
    cfg_tom_mb = 12'hFFF;
    do_req(36'h7FF0_0000, 0, 0);     // R8 below cap
    do_req(36'h8000_0000, 1, 0);     // R8 at cap -> hub

    // constrained random
    for (int n = 0; n < 3000; n++) begin
      bit io;
      logic [ADDR_W-1:0] a;
      if (n % 50 == 0) begin
        cfg_tom_mb    = 12'($urandom);
        cfg_vga_route = 2'($urandom);
        cfg_low_attr  = 16'($urandom);
      end
      a = rnd_addr(io);
      do_req(a, bit'($urandom % 2), io);
      if (n % 7 == 0) begin
        @(negedge clk);
        check("R1 gap", 64'({tgt_valid, tgt_sel, cpl_valid}), 0);
      end
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule